// File: doc/BRIEF.md
# Four-Bank Register File with Arbitrated Read Ports

This register file spreads its registers over four banks by the two low bits of the register number. Each bank has one physical read port and one physical write port. The four banks work side by side, so the block behaves like a file with four read and four write ports whenever the requests of a cycle land on different banks.

Each cycle, up to four requesters present a read. Every bank picks the lowest-numbered port that addresses it. Any other port asking for that same register rides along for free, and every remaining port on that bank is refused for the cycle. A refused requester sees its grant low and must ask again. A granted read delivers its value one clock later, marked by a per-port valid.

Writes follow the same lowest-port-wins rule. Two writes to one bank raise an error flag. Any cycle in which some read is refused raises a conflict flag and bumps a saturating counter.

Top module: `banked_regfile`

## Requirements
- R1: While reset is held and right after it, every `rd_valid` bit is 0 and `conflict_cnt` is 0.
- R2: A register's bank is its number modulo 4 (address bits [1:0]). Four reads that address four different banks are all granted in the same cycle.
- R3: Per bank and per cycle, at most one distinct register is read. The lowest-numbered requesting port on a bank is always granted. A port on that bank that asks for a different register gets `rd_grant` low.
- R4: Ports that ask for the same register as the winning port of its bank are all granted, and they all receive the same value.
- R5: A port granted in cycle t shows `rd_valid` high and the register's value on `rd_data` in cycle t+1. A read and a write of the same register in one cycle returns the value held before the write.
- R6: Any pair of reads to registers 2k and 2k+1 is served in one cycle, with both ports granted.
- R7: Four writes to four different banks all take effect at the same clock edge. Reads issued from the next cycle on return the new values.
- R8: When two or more writes address one bank in a cycle, only the lowest-numbered of those ports is written, and `wr_err` is high in that same cycle.
- R9: `rd_conflict` is high in any cycle in which at least one requested read is not granted. `conflict_cnt` then rises by one at the next edge and stops at all ones.
- R10: A port whose `rd_req` is low is never granted, whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_req | input | 4 | Read request, one bit per port |
| rd_addr | input | 4 x ADDR_W | Register number per read port |
| wr_en | input | 4 | Write request, one bit per port |
| wr_addr | input | 4 x ADDR_W | Register number per write port |
| wr_data | input | 4 x DATA_W | Write value per port |
| rd_grant | output | 4 | Read accepted this cycle, per port |
| rd_valid | output | 4 | `rd_data` holds the result of last cycle's granted read |
| rd_data | output | 4 x DATA_W | Read result per port |
| rd_conflict | output | 1 | Some read was refused this cycle |
| wr_err | output | 1 | Two or more writes hit one bank this cycle |
| conflict_cnt | output | CNT_W | Saturating count of cycles with a refused read |

## Verification
The bench builds the block with 16 registers, 16-bit data and a 6-bit conflict counter. With those values each bank holds only four rows, so random traffic collides often and covers same-register merges and refusals in good number. The short counter also reaches its saturation point after a few dozen conflicting cycles, so the hold at all ones is observed directly rather than left to the 16-bit default.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int NPORT  = 4;
  localparam int NBANK  = 4;
  localparam int BANK_W = $clog2(NBANK);
  localparam int PORT_W = $clog2(NPORT);

  typedef logic [NPORT-1:0] port_mask_t;
endpackage

// File: rtl/rfb_bank_arb.sv
module rfb_bank_arb
  import rfb_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int BANK_ID = 0,
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  port_mask_t        rd_req,
  input  logic [ADDR_W-1:0] rd_addr [NPORT],
  input  port_mask_t        wr_en,
  input  logic [ADDR_W-1:0] wr_addr [NPORT],
  output port_mask_t        rd_gnt,
  output logic              bank_rd_en,
  output logic [ROW_W-1:0]  bank_rd_row,
  output logic              bank_we,
  output logic [ROW_W-1:0]  bank_wr_row,
  output logic [PORT_W-1:0] wr_sel,
  output logic              wr_clash
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

  logic [ADDR_W-1:0] rd_win;
  logic [ADDR_W-1:0] wr_win;
  int unsigned       wr_hits;

  // read side: lowest requesting port on this bank wins, same-register ports merge
  always_comb begin
    bank_rd_en = 1'b0;
    rd_win     = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (rd_req[p] && (rd_addr[p][BANK_W-1:0] == MY_BANK) && !bank_rd_en) begin
        bank_rd_en = 1'b1;
        rd_win     = rd_addr[p];
      end
    end
    for (int p = 0; p < NPORT; p++) begin
      rd_gnt[p] = bank_rd_en && rd_req[p] && (rd_addr[p] == rd_win);
    end
    bank_rd_row = rd_win[ADDR_W-1:BANK_W];
  end

  // write side: lowest port wins, more than one is a clash
  always_comb begin
    bank_we = 1'b0;
    wr_win  = '0;
    wr_sel  = '0;
    wr_hits = 0;
    for (int p = 0; p < NPORT; p++) begin
      if (wr_en[p] && (wr_addr[p][BANK_W-1:0] == MY_BANK)) begin
        wr_hits = wr_hits + 1;
        if (!bank_we) begin
          bank_we = 1'b1;
          wr_win  = wr_addr[p];
          wr_sel  = PORT_W'(p);
        end
      end
    end
    wr_clash    = (wr_hits > 1);
    bank_wr_row = wr_win[ADDR_W-1:BANK_W];
  end

  always_comb begin
    AST_GRANT_IMPLIES_ENABLE: assert (!(|rd_gnt) || bank_rd_en); // R3
  end
endmodule

// File: rtl/rfb_bank_store.sv
module rfb_bank_store #(
  parameter int ROWS   = 8,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic              we,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] rd_d;

  // array: no reset, single write port
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wr_row] <= wr_val;
    end
  end

  // single read port, registered; sees contents from before this edge's write
  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = mem[rd_row];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end
endmodule

// File: rtl/rfb_sat_counter.sv
module rfb_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = inc && (cnt_q != '1);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_STICKS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) |=> (cnt_q == '1)); // R9
  AST_CNT_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rfb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORT-1:0]  rd_req,
  input  logic [ADDR_W-1:0] rd_addr [NPORT],
  input  logic [NPORT-1:0]  wr_en,
  input  logic [ADDR_W-1:0] wr_addr [NPORT],
  input  logic [DATA_W-1:0] wr_data [NPORT],
  output logic [NPORT-1:0]  rd_grant,
  output logic [NPORT-1:0]  rd_valid,
  output logic [DATA_W-1:0] rd_data [NPORT],
  output logic              rd_conflict,
  output logic              wr_err,
  output logic [CNT_W-1:0]  conflict_cnt
);
  localparam int ROWS  = NUM_REGS / NBANK;
  localparam int ROW_W = ADDR_W - BANK_W;

  port_mask_t        bank_gnt    [NBANK];
  logic              bank_rd_en  [NBANK];
  logic [ROW_W-1:0]  bank_rd_row [NBANK];
  logic              bank_we     [NBANK];
  logic [ROW_W-1:0]  bank_wr_row [NBANK];
  logic [PORT_W-1:0] bank_wr_sel [NBANK];
  logic [NBANK-1:0]  bank_clash;
  logic [DATA_W-1:0] bank_q      [NBANK];

  logic [BANK_W-1:0] sel_q [NPORT];
  logic [BANK_W-1:0] sel_d [NPORT];
  logic [NPORT-1:0]  valid_d;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rfb_bank_arb #(
      .ADDR_W (ADDR_W),
      .BANK_ID(b)
    ) u_arb (
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .rd_gnt     (bank_gnt[b]),
      .bank_rd_en (bank_rd_en[b]),
      .bank_rd_row(bank_rd_row[b]),
      .bank_we    (bank_we[b]),
      .bank_wr_row(bank_wr_row[b]),
      .wr_sel     (bank_wr_sel[b]),
      .wr_clash   (bank_clash[b])
    );

    rfb_bank_store #(
      .ROWS  (ROWS),
      .DATA_W(DATA_W)
    ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (bank_rd_en[b]),
      .rd_row(bank_rd_row[b]),
      .we    (bank_we[b]),
      .wr_row(bank_wr_row[b]),
      .wr_val(wr_data[bank_wr_sel[b]]),
      .rd_q  (bank_q[b])
    );
  end

  // each port belongs to exactly one bank, so OR-ing the bank masks is exact
  always_comb begin
    rd_grant = '0;
    for (int b = 0; b < NBANK; b++) begin
      rd_grant = rd_grant | bank_gnt[b];
    end
    rd_conflict = |(rd_req & ~rd_grant);
    wr_err      = |bank_clash;
  end

  // remember which bank served each port for the return cycle
  always_comb begin
    valid_d = rd_grant;
    for (int p = 0; p < NPORT; p++) begin
      sel_d[p] = rd_grant[p] ? rd_addr[p][BANK_W-1:0] : sel_q[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= '0;
      for (int p = 0; p < NPORT; p++) begin
        sel_q[p] <= '0;
      end
    end else begin
      rd_valid <= valid_d;
      for (int p = 0; p < NPORT; p++) begin
        sel_q[p] <= sel_d[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rd_data[p] = bank_q[sel_q[p]];
    end
  end

  rfb_sat_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (rd_conflict),
    .cnt_q(conflict_cnt)
  );

  // ---------------- assertions ----------------
  AST_PORT0_ALWAYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req[0] |-> rd_grant[0]); // R3

  AST_CONFLICT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_conflict && (conflict_cnt != '1)) |=>
      (conflict_cnt == CNT_W'($past(conflict_cnt) + 1'b1))); // R9

  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    AST_IDLE_NEVER_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req[p] |-> !rd_grant[p]); // R10
    AST_GRANT_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[p] |=> rd_valid[p]); // R5
    for (genvar q = p + 1; q < NPORT; q++) begin : g_pair_chk
      AST_ONE_ROW_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant[p] && rd_grant[q] &&
         (rd_addr[p][BANK_W-1:0] == rd_addr[q][BANK_W-1:0])) |->
          (rd_addr[p] == rd_addr[q])); // R3
      AST_WRITE_CLASH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[p] && wr_en[q] &&
         (wr_addr[p][BANK_W-1:0] == wr_addr[q][BANK_W-1:0])) |-> wr_err); // R8
    end
  end
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int NREG = 16;
  localparam int DW   = 16;
  localparam int CW   = 6;
  localparam int AW   = $clog2(NREG);
  localparam int NP   = 4;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] rd_req;
  logic [AW-1:0] rd_addr [NP];
  logic [NP-1:0] wr_en;
  logic [AW-1:0] wr_addr [NP];
  logic [DW-1:0] wr_data [NP];
  logic [NP-1:0] rd_grant;
  logic [NP-1:0] rd_valid;
  logic [DW-1:0] rd_data [NP];
  logic          rd_conflict;
  logic          wr_err;
  logic [CW-1:0] conflict_cnt;

  banked_regfile #(.NUM_REGS(NREG), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_grant(rd_grant), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_conflict(rd_conflict), .wr_err(wr_err), .conflict_cnt(conflict_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // staged stimulus
  logic [NP-1:0] s_rq;
  int            s_ra [NP];
  logic [NP-1:0] s_wq;
  int            s_wa [NP];
  int            s_wd [NP];

  // reference state
  int mdl_mem [NREG];
  int mdl_cnt;
  logic [NP-1:0] exp_val;
  int            exp_dat [NP];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr();
    s_rq = '0;
    s_wq = '0;
    for (int p = 0; p < NP; p++) begin
      s_ra[p] = 0; s_wa[p] = 0; s_wd[p] = 0;
    end
  endtask

  task automatic rdp(input int p, input int a);
    s_rq[p] = 1'b1; s_ra[p] = a;
  endtask

  task automatic wrp(input int p, input int a, input int d);
    s_wq[p] = 1'b1; s_wa[p] = a; s_wd[p] = d;
  endtask

  task automatic step();
    logic [NP-1:0] g;
    bit conf, werr;
    int win;
    int wlist [4];
    @(negedge clk);
    rd_req = s_rq;
    wr_en  = s_wq;
    for (int p = 0; p < NP; p++) begin
      rd_addr[p] = AW'(s_ra[p]);
      wr_addr[p] = AW'(s_wa[p]);
      wr_data[p] = DW'(s_wd[p]);
    end
    #1;
    // expected grants: winner is the first requester of the bank; matches merge (R3, R4, R10)
    conf = 1'b0;
    for (int p = 0; p < NP; p++) begin
      win = -1;
      for (int q = 0; q < NP; q++) begin
        if (win < 0 && s_rq[q] && (s_ra[q] % 4) == (s_ra[p] % 4)) win = q;
      end
      g[p] = s_rq[p] && (win >= 0) && (s_ra[win] == s_ra[p]);
      if (s_rq[p] && !g[p]) conf = 1'b1;
      exp_dat[p] = g[p] ? mdl_mem[s_ra[p]] : 0;
    end
    exp_val = g;
    chk(rd_grant == g, "R3 grant", rd_grant, g);
    chk(rd_conflict == conf, "R9 conflict flag", rd_conflict, conf);
    werr = 1'b0;
    for (int b = 0; b < 4; b++) wlist[b] = -1;
    for (int p = 0; p < NP; p++) begin
      if (s_wq[p]) begin
        if (wlist[s_wa[p] % 4] < 0) wlist[s_wa[p] % 4] = p;
        else werr = 1'b1;
      end
    end
    chk(wr_err == werr, "R8 write error flag", wr_err, werr);
    @(posedge clk);
    // writes land after the read was taken (R5, R7, R8)
    for (int b = 0; b < 4; b++) begin
      if (wlist[b] >= 0) mdl_mem[s_wa[wlist[b]]] = s_wd[wlist[b]] & ((1 << DW) - 1);
    end
    if (conf && mdl_cnt < (1 << CW) - 1) mdl_cnt++;
    #1;
    chk(rd_valid == exp_val, "R5 valid", rd_valid, exp_val);
    for (int p = 0; p < NP; p++) begin
      if (exp_val[p]) chk(rd_data[p] == DW'(exp_dat[p]), "R5 data", rd_data[p], exp_dat[p]);
    end
    chk(conflict_cnt == CW'(mdl_cnt), "R9 counter", conflict_cnt, mdl_cnt);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mdl_cnt = 0;
    for (int r = 0; r < NREG; r++) mdl_mem[r] = 0;
    rst_n  = 1'b0;
    rd_req = '0;
    wr_en  = '0;
    for (int p = 0; p < NP; p++) begin
      rd_addr[p] = '0; wr_addr[p] = '0; wr_data[p] = '0;
    end
    clr();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_valid == '0, "R1 valid in reset", rd_valid, 0);
    chk(conflict_cnt == '0, "R1 counter in reset", conflict_cnt, 0);
    rst_n = 1'b1;

    // R7: fill four banks per cycle
    for (int r = 0; r < NREG; r += 4) begin
      clr();
      for (int p = 0; p < NP; p++) wrp(p, r + p, 16'h1000 + (r + p) * 16'h0111);
      step();
    end
    // R1: state just after reset
    chk(rd_valid == '0 && conflict_cnt == '0, "R1 after reset", conflict_cnt, 0);

    // R2: four distinct banks
    clr(); rdp(0, 5); rdp(1, 2); rdp(2, 15); rdp(3, 8); step();
    // R3: all on bank 1, different rows
    clr(); rdp(0, 1); rdp(1, 5); rdp(2, 9); rdp(3, 13); step();
    // R3: port 0 idle, port 1 wins bank 0
    clr(); rdp(1, 4); rdp(2, 0); rdp(3, 12); step();
    // R4: ports 0 and 2 share register 6
    clr(); rdp(0, 6); rdp(1, 10); rdp(2, 6); rdp(3, 3); step();
    // R6: even/odd pair
    clr(); rdp(2, 12); rdp(3, 13); step();
    clr(); rdp(0, 7); rdp(1, 6); step();
    // R8: ports 1 and 3 write bank 2
    clr(); wrp(0, 0, 16'hAAAA); wrp(1, 2, 16'hBBBB); wrp(3, 14, 16'hCCCC); step();
    clr(); rdp(0, 2); rdp(1, 14); rdp(2, 0); step();
    // R5: read and write same register in one cycle
    clr(); rdp(1, 7); wrp(2, 7, 16'h7777); step();
    clr(); rdp(3, 7); step();
    // R10: addresses present, no request
    clr(); s_ra[0] = 3; s_ra[1] = 3; s_ra[2] = 9; s_ra[3] = 1; step();

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      clr();
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 3) != 0) rdp(p, $urandom_range(0, NREG - 1));
        if ($urandom_range(0, 4) == 0) wrp(p, $urandom_range(0, NREG - 1), $urandom_range(0, 16'hFFFF));
      end
      step();
    end

    // R9: drive the counter into saturation
    for (int i = 0; i < 70; i++) begin
      clr(); rdp(0, 0); rdp(1, 4); step();
    end
    chk(conflict_cnt == {CW{1'b1}}, "R9 saturated", conflict_cnt, (1 << CW) - 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule